// File: doc/BRIEF.md
# Receive Buffer Ring Controller

This block fills receive buffers for a host driver. The buffers are described by a circular ring of 32-bit descriptors in host memory. Software programs the ring base address, the base address of a small status area and a configuration word. It then publishes free descriptors by moving a producer index forward. The controller keeps its own fill index. For each free descriptor it reads the entry through a simple request/acknowledge memory port and offers the buffer that the entry points to. It waits for the end of an incoming frame, then advances its fill index and writes the index of the descriptor it just filled into the status area.

The data transfer itself is outside the block. A frame arriving into the offered buffer appears only as an end pulse with a byte length. The controller stops before its fill index catches up with the producer index, so at least one descriptor always stays unfilled. It notifies the host either at once after each status write or after a programmable quiet period counted from a microsecond tick. Software can stop the channel at once, or let the buffer already offered complete before the channel pauses. An idle output shows when nothing is in flight.

The main state machine has four states. IDLE waits for room and a run command. FETCH holds a descriptor read until it is acknowledged. OPEN offers the buffer until a frame fits it. WBACK holds the status write until it is acknowledged. Its transitions are:
- IDLE to FETCH when the mode is normal and the ring has room.
- FETCH to OPEN on acknowledge in normal mode.
- FETCH to IDLE on acknowledge in any other mode.
- OPEN to IDLE when the mode becomes stopped.
- OPEN to WBACK when a fitting frame ends.
- WBACK to IDLE on acknowledge.

The interrupt timer has two states, disarmed and armed.

Top module: `rxring_ctrl`

## Requirements
- R1: A register write with `reg_sel`=0 sets the ring base from `reg_wdata[27:0]`, which gives address bits 35:8. Each descriptor read goes to ring base×256 + 4×(fill index). The request stays asserted with a stable address until `mem_ack`.
- R2: A descriptor's bits 27:0 give buffer address bits 35:8, and `buf_addr` presents that address. Config bits 17:16 select the buffer capacity as (value+1)×4096 bytes. A frame end whose length fits the capacity fills the buffer and advances the fill index by one, modulo the ring size.
- R3: A frame end whose length exceeds the capacity is dropped. The fill index does not move, no status is written and the same buffer stays offered.
- R4: `reg_sel`=1 sets the status base from all 32 bits, which give address bits 35:4. After each fill, one write to status base×16 carries the filled descriptor's index in bits 11:0, with bits 31:12 zero.
- R5: When the masked fill index equals the masked producer index, the ring is full and no descriptor is read.
- R6: `reg_sel`=2 sets the producer index from `reg_wdata[11:0]`. A value whose low three bits are not zero is ignored.
- R7: `reg_sel`=3 writes the config word. Bits 23:20 give log2 of the ring size, clamped to the range 5 to 12. Both indices are compared and wrapped with mask size−1.
- R8: Config bits 31:30 select the mode. 10 means normal operation. 01 completes a buffer that is already offered, then starts no new fetch. 00 and 11 stop at once: an offered buffer is abandoned without filling, and the same descriptor is fetched again when the channel restarts.
- R9: `chan_idle` is high after reset and whenever no descriptor read, offered buffer or status write is in progress. While it is high, no request is made and no buffer is offered.
- R10: If config bits 13:12 equal 01 and bits 11:4 are zero, `host_irq` pulses for exactly one cycle, in the cycle after the status write is accepted.
- R11: If bits 11:4 hold T>0, the pulse comes after 32×T ticks counted from the last accepted status write, and each new status write restarts the count. With bits 13:12 other than 01, no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 ring base, 1 status base, 2 producer index, 3 config |
| reg_wdata | input | 32 | Register write data |
| frm_end | input | 1 | End of a frame received into the offered buffer |
| frm_len | input | 14 | Byte length of the ending frame |
| buf_rdy | output | 1 | A buffer is offered |
| buf_addr | output | 36 | Address of the offered buffer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for the status write, 0 for a descriptor read |
| mem_addr | output | 36 | Memory byte address |
| mem_wdata | output | 32 | Status word |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 28 | Descriptor read data (buffer address bits 35:8) |
| tick_us | input | 1 | One-microsecond tick |
| host_irq | output | 1 | Host interrupt pulse |
| chan_idle | output | 1 | Nothing in flight |
| fill_idx | output | 12 | Current masked fill index |

## Verification
The checker watches several properties on every cycle:
- a held request keeps its address until acknowledged;
- descriptor reads happen only when the ring has room;
- the status word has clear upper bits;
- the idle flag excludes requests and offers;
- the interrupt lasts one cycle;
- the fill index only ever steps by one modulo the ring size.

Some behaviour can only be shown by the bench scenarios:
- exact descriptor and status addresses;
- wrap-around over several ring sizes;
- rejection of oversize frames and misaligned producer writes;
- size clamping;
- the stop and pause-after-frame modes;
- the exact tick count before a timed interrupt and its restart.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OPEN,
        ST_WBACK
    } rx_state_t;

    typedef enum logic [1:0] {
        RUN_OFF   = 2'b00,
        RUN_DRAIN = 2'b01,
        RUN_ON    = 2'b10,
        RUN_RSVD  = 2'b11
    } run_mode_t;

    typedef enum logic {
        TM_DISARMED,
        TM_ARMED
    } tmr_state_t;

    typedef struct packed {
        run_mode_t  mode;
        logic [3:0] log_sz;
        logic [1:0] buf_sz;
        logic [1:0] irq_tgt;
        logic [7:0] tmo;
    } rx_cfg_t;

    localparam logic [1:0] SEL_RING = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_PROD = 2'd2;
    localparam logic [1:0] SEL_CFG  = 2'd3;

    localparam logic [1:0] TGT_HOST = 2'b01;

endpackage

// File: rtl/rxring_regs.sv
module rxring_regs
    import rxring_pkg::*;
#(
    parameter int IDX_W   = 12,
    parameter int MIN_LOG = 5,
    parameter int MAX_LOG = 12,
    parameter int RB_W    = 28,
    parameter int SB_W    = 32,
    parameter int CAP_W   = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [RB_W-1:0]  ring_base,
    output logic [SB_W-1:0]  stat_base,
    output logic [IDX_W-1:0] prod_idx,
    output logic [IDX_W-1:0] idx_mask,
    output logic [CAP_W-1:0] buf_cap,
    output rx_cfg_t          cfg
);
    localparam logic [3:0] LOG_LO = 4'(MIN_LOG);
    localparam logic [3:0] LOG_HI = 4'(MAX_LOG);

    logic [RB_W-1:0]  ring_q;
    logic [SB_W-1:0]  stat_q;
    logic [IDX_W-1:0] prod_q;
    rx_cfg_t          cfg_q;
    logic [3:0]       log_clamped;
    logic [2:0]       cap_units;

    always_comb begin
        if (reg_wdata[23:20] < LOG_LO)
            log_clamped = LOG_LO;
        else if (reg_wdata[23:20] > LOG_HI)
            log_clamped = LOG_HI;
        else
            log_clamped = reg_wdata[23:20];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q         <= '0;
            stat_q         <= '0;
            prod_q         <= '0;
            cfg_q.mode     <= RUN_OFF;
            cfg_q.log_sz   <= LOG_LO;
            cfg_q.buf_sz   <= 2'b00;
            cfg_q.irq_tgt  <= 2'b00;
            cfg_q.tmo      <= 8'h00;
        end else if (reg_wr) begin
            unique case (reg_sel)
                SEL_RING: ring_q <= reg_wdata[RB_W-1:0];
                SEL_STAT: stat_q <= reg_wdata[SB_W-1:0];
                SEL_PROD: begin
                    if (reg_wdata[2:0] == 3'b000)
                        prod_q <= reg_wdata[IDX_W-1:0];
                end
                SEL_CFG: begin
                    cfg_q.mode    <= run_mode_t'(reg_wdata[31:30]);
                    cfg_q.log_sz  <= log_clamped;
                    cfg_q.buf_sz  <= reg_wdata[17:16];
                    cfg_q.irq_tgt <= reg_wdata[13:12];
                    cfg_q.tmo     <= reg_wdata[11:4];
                end
                default: ;
            endcase
        end
    end

    assign cap_units = {1'b0, cfg_q.buf_sz} + 3'd1;

    assign ring_base = ring_q;
    assign stat_base = stat_q;
    assign prod_idx  = prod_q;
    assign cfg       = cfg_q;
    assign idx_mask  = ~({IDX_W{1'b1}} << cfg_q.log_sz);
    assign buf_cap   = CAP_W'({cap_units, 12'h000});

endmodule

// File: rtl/rxring_timer.sv
module rxring_timer
    import rxring_pkg::*;
#(
    parameter int TMO_W = 8,
    parameter int SUB_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [TMO_W-1:0] tmo,
    input  logic             host_en,
    output logic             irq
);
    tmr_state_t       st_q;
    logic [SUB_W-1:0] sub_q;
    logic [TMO_W-1:0] unit_q;
    logic [TMO_W-1:0] unit_nx;
    logic             irq_q;
    logic             sub_wrap;

    assign sub_wrap = (sub_q == {SUB_W{1'b1}});
    assign unit_nx  = unit_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= TM_DISARMED;
            sub_q  <= '0;
            unit_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (restart) begin
                sub_q  <= '0;
                unit_q <= '0;
                st_q   <= (tmo != '0) ? TM_ARMED : TM_DISARMED;
                irq_q  <= host_en && (tmo == '0);
            end else if (st_q == TM_ARMED && tick) begin
                sub_q <= sub_q + 1'b1;
                if (sub_wrap) begin
                    unit_q <= unit_nx;
                    if (unit_nx == tmo) begin
                        st_q  <= TM_DISARMED;
                        irq_q <= host_en;
                    end
                end
            end
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/rxring_fsm.sv
module rxring_fsm
    import rxring_pkg::*;
#(
    parameter int IDX_W = 12,
    parameter int LEN_W = 14,
    parameter int AW    = 36,
    parameter int RB_W  = 28,
    parameter int SB_W  = 32,
    parameter int CAP_W = 15,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  run_mode_t        mode,
    input  logic [RB_W-1:0]  ring_base,
    input  logic [SB_W-1:0]  stat_base,
    input  logic [IDX_W-1:0] prod_idx,
    input  logic [IDX_W-1:0] idx_mask,
    input  logic [CAP_W-1:0] buf_cap,
    input  logic             frm_end,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             mem_ack,
    input  logic [RB_W-1:0]  mem_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             buf_rdy,
    output logic [AW-1:0]    buf_addr,
    output logic [IDX_W-1:0] fill_idx,
    output logic             fill_done,
    output logic             chan_idle
);
    localparam int RB_SH = AW - RB_W;
    localparam int SB_SH = AW - SB_W;

    rx_state_t        state_q, state_d;
    logic [IDX_W-1:0] fill_q, fill_m, last_q;
    logic [AW-1:0]    buf_q;
    logic             room, run_on, run_stop, fits, take_frame;

    assign fill_m     = fill_q & idx_mask;
    assign room       = ((fill_q ^ prod_idx) & idx_mask) != '0;
    assign run_on     = (mode == RUN_ON);
    assign run_stop   = (mode == RUN_OFF) || (mode == RUN_RSVD);
    assign fits       = CAP_W'(frm_len) <= buf_cap;
    assign take_frame = (state_q == ST_OPEN) && !run_stop && frm_end && fits;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_on && room) state_d = ST_FETCH;
            ST_FETCH: if (mem_ack) state_d = run_on ? ST_OPEN : ST_IDLE;
            ST_OPEN: begin
                if (run_stop)        state_d = ST_IDLE;
                else if (take_frame) state_d = ST_WBACK;
            end
            ST_WBACK: if (mem_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        buf_rdy   = 1'b0;
        fill_done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {ring_base, {RB_SH{1'b0}}} + AW'({fill_m, 2'b00});
            end
            ST_OPEN: buf_rdy = !run_stop;
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {stat_base, {SB_SH{1'b0}}};
                mem_wdata = DW'(last_q);
                fill_done = mem_ack;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            last_q <= '0;
            buf_q  <= '0;
        end else begin
            if (state_q == ST_FETCH && mem_ack)
                buf_q <= {mem_rdata, {RB_SH{1'b0}}};
            if (take_frame) begin
                last_q <= fill_m;
                fill_q <= (fill_m + 1'b1) & idx_mask;
            end
        end
    end

    assign buf_addr  = buf_q;
    assign fill_idx  = fill_m;
    assign chan_idle = (state_q == ST_IDLE);

endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
    import rxring_pkg::*;
#(
    parameter int IDX_W   = 12,
    parameter int LEN_W   = 14,
    parameter int MIN_LOG = 5,
    parameter int AW      = 36,
    parameter int DW      = 32,
    parameter int TMO_W   = 8,
    parameter int SUB_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [DW-1:0]    reg_wdata,
    input  logic             frm_end,
    input  logic [LEN_W-1:0] frm_len,
    output logic             buf_rdy,
    output logic [AW-1:0]    buf_addr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [AW-9:0]    mem_rdata,
    input  logic             tick_us,
    output logic             host_irq,
    output logic             chan_idle,
    output logic [IDX_W-1:0] fill_idx
);
    localparam int RB_W  = AW - 8;
    localparam int SB_W  = AW - 4;
    localparam int CAP_W = LEN_W + 1;

    logic [RB_W-1:0]  ring_base;
    logic [SB_W-1:0]  stat_base;
    logic [IDX_W-1:0] prod_idx;
    logic [IDX_W-1:0] idx_mask;
    logic [CAP_W-1:0] buf_cap;
    rx_cfg_t          cfg;
    logic             fill_done;

    rxring_regs #(
        .IDX_W(IDX_W), .MIN_LOG(MIN_LOG), .MAX_LOG(IDX_W),
        .RB_W(RB_W), .SB_W(SB_W), .CAP_W(CAP_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ring_base(ring_base), .stat_base(stat_base),
        .prod_idx(prod_idx), .idx_mask(idx_mask), .buf_cap(buf_cap), .cfg(cfg)
    );

    rxring_fsm #(
        .IDX_W(IDX_W), .LEN_W(LEN_W), .AW(AW), .RB_W(RB_W),
        .SB_W(SB_W), .CAP_W(CAP_W), .DW(DW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode(cfg.mode), .ring_base(ring_base),
        .stat_base(stat_base), .prod_idx(prod_idx), .idx_mask(idx_mask),
        .buf_cap(buf_cap), .frm_end(frm_end), .frm_len(frm_len),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .buf_rdy(buf_rdy), .buf_addr(buf_addr), .fill_idx(fill_idx),
        .fill_done(fill_done), .chan_idle(chan_idle)
    );

    rxring_timer #(
        .TMO_W(TMO_W), .SUB_W(SUB_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .restart(fill_done),
        .tmo(cfg.tmo), .host_en(cfg.irq_tgt == TGT_HOST), .irq(host_irq)
    );

endmodule

// File: rtl/rxring_ctrl_chk.sv
module rxring_ctrl_chk #(
    parameter int IDX_W = 12,
    parameter int AW    = 36,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [AW-1:0]    mem_addr,
    input logic [DW-1:0]    mem_wdata,
    input logic             buf_rdy,
    input logic             chan_idle,
    input logic             host_irq,
    input logic [IDX_W-1:0] fill_idx,
    input logic [IDX_W-1:0] prod_idx,
    input logic [IDX_W-1:0] idx_mask
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R1

    AST_FETCH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> ((fill_idx ^ prod_idx) & idx_mask) != '0); // R5

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[DW-1:IDX_W] == '0); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        chan_idle |-> !mem_req && !buf_rdy); // R9

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> !host_irq); // R10

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fill_idx) && $stable(idx_mask)
            |-> fill_idx == (($past(fill_idx) + 1'b1) & idx_mask)); // R2

endmodule

bind rxring_ctrl rxring_ctrl_chk #(.IDX_W(IDX_W), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .buf_rdy(buf_rdy), .chan_idle(chan_idle), .host_irq(host_irq),
    .fill_idx(fill_idx), .prod_idx(prod_idx), .idx_mask(idx_mask)
);

// File: tb/rxring_ctrl_bench.sv
module rxring_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [27:0] RB = 28'h0123450;
    localparam logic [31:0] SB = 32'h00ABCDE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        frm_end = 1'b0;
    logic [13:0] frm_len = 14'd0;
    logic        buf_rdy;
    logic [35:0] buf_addr;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [27:0] mem_rdata;
    logic        tick_us = 1'b0;
    logic        host_irq, chan_idle;
    logic [11:0] fill_idx;

    int vectors = 0;
    int miscompares = 0;
    int fetch_cnt, wb_cnt, exp_fetch;
    logic [35:0] last_fetch, wb_addr;
    logic [31:0] wb_data;
    logic [11:0] mask, exp_fill, prod;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxring_ctrl u_rxring_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .frm_end(frm_end), .frm_len(frm_len),
        .buf_rdy(buf_rdy), .buf_addr(buf_addr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tick_us(tick_us),
        .host_irq(host_irq), .chan_idle(chan_idle), .fill_idx(fill_idx)
    );

    function automatic logic [27:0] desc_of(input logic [11:0] idx);
        return 28'h0A00000 + 28'(idx) * 28'h13;
    endfunction

    function automatic logic [31:0] cfgw(input logic [1:0] md, input logic [3:0] lg,
                                         input logic [1:0] bs, input logic [1:0] tg,
                                         input logic [7:0] tm);
        return {md, 6'b0, lg, 2'b0, bs, 2'b0, tg, tm, 4'b0};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            fetch_cnt <= 0;
            wb_cnt    <= 0;
            last_fetch <= '0;
            wb_addr   <= '0;
            wb_data   <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                wb_cnt  <= wb_cnt + 1;
                wb_addr <= mem_addr;
                wb_data <= mem_wdata;
            end else begin
                fetch_cnt  <= fetch_cnt + 1;
                last_fetch <= mem_addr;
                mem_rdata  <= desc_of(12'((mem_addr - {RB, 8'h00}) >> 2));
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; reg_wr = 1'b0; frm_end = 1'b0; tick_us = 1'b0;
        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_rdy;
        int w;
        w = 0;
        while (!buf_rdy && w < 100) begin @(negedge clk); w++; end
    endtask

    task automatic do_fill(input logic [11:0] idx, input logic [13:0] len,
                           input int exp_first, input int span, input string irq_tag);
        int n0, w, first;
        wait_rdy();
        chk(buf_rdy, "R2 buffer offered", buf_rdy, 1);
        chk(last_fetch == {RB, 8'h00} + 36'(idx) * 36'd4, "R1 fetch address",
            last_fetch, {RB, 8'h00} + 36'(idx) * 36'd4);
        chk(buf_addr == {desc_of(idx), 8'h00}, "R2 buffer address",
            buf_addr, {desc_of(idx), 8'h00});
        n0 = wb_cnt;
        frm_end = 1'b1; frm_len = len;
        @(negedge clk);
        frm_end = 1'b0;
        w = 0;
        while (wb_cnt == n0 && w < 50) begin @(negedge clk); w++; end
        chk(wb_cnt == n0 + 1, "R4 status write issued", wb_cnt, n0 + 1);
        chk(wb_addr == {SB, 4'h0}, "R4 status address", wb_addr, {SB, 4'h0});
        chk(wb_data == 32'(idx), "R4 status data", wb_data, 32'(idx));
        chk(fill_idx == ((idx + 12'd1) & mask), "R2 fill advance",
            fill_idx, (idx + 12'd1) & mask);
        first = 0;
        for (int n = 1; n <= span; n++) begin
            @(negedge clk);
            if (host_irq && first == 0) first = n;
        end
        chk(first == exp_first, irq_tag, first, exp_first);
        exp_fetch++;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        do_reset();
        chk(chan_idle == 1'b1, "R9 idle after reset", chan_idle, 1);
        chk(mem_req == 1'b0, "R9 no request after reset", mem_req, 0);
        chk(buf_rdy == 1'b0, "R9 no offer after reset", buf_rdy, 0);
        chk(host_irq == 1'b0, "R10 no irq after reset", host_irq, 0);
        chk(fill_idx == 12'd0, "R2 fill index after reset", fill_idx, 0);

        for (int lg = 6; lg >= 5; lg--) begin
            do_reset();
            mask = 12'((1 << lg) - 1);
            exp_fetch = 0;
            wr(2'd0, {4'h0, RB});
            wr(2'd1, SB);
            wr(2'd3, cfgw(2'b10, 4'(lg), 2'b00, 2'b01, 8'h00));
            if (lg == 6) begin
                wr(2'd2, 32'd4);
                idle_cycles(10);
                chk(fetch_cnt == 0, "R6 misaligned producer ignored", fetch_cnt, 0);
                chk(chan_idle, "R9 idle with empty ring", chan_idle, 1);
            end
            exp_fill = 12'd0;
            prod = 12'd0;
            for (int r = 0; r < (1 << lg) / 8 + 2; r++) begin
                prod = (prod + 12'd8) & mask;
                wr(2'd2, 32'(prod));
                for (int k = 0; k < 8; k++) begin
                    do_fill(exp_fill, 14'(100 + k), 1, 3, "R10 immediate irq");
                    exp_fill = (exp_fill + 12'd1) & mask;
                end
                idle_cycles(10);
                chk(fetch_cnt == exp_fetch, "R5 no fetch when full", fetch_cnt, exp_fetch);
                chk(fill_idx == prod, "R5 fill stops at producer", fill_idx, prod);
                chk(chan_idle, "R9 idle when full", chan_idle, 1);
            end
        end

        prod = (prod + 12'd8) & mask;
        wr(2'd2, 32'(prod));
        wait_rdy();
        frm_end = 1'b1; frm_len = 14'd4097;
        @(negedge clk);
        frm_end = 1'b0;
        idle_cycles(10);
        chk(wb_cnt == exp_fetch, "R3 oversize frame not written", wb_cnt, exp_fetch);
        chk(buf_rdy, "R3 buffer still offered", buf_rdy, 1);
        chk(fill_idx == exp_fill, "R3 fill index unchanged", fill_idx, exp_fill);
        do_fill(exp_fill, 14'd4096, 1, 3, "R10 immediate irq");
        exp_fill = (exp_fill + 12'd1) & mask;

        wr(2'd3, cfgw(2'b10, 4'd5, 2'b01, 2'b01, 8'h00));
        do_fill(exp_fill, 14'd8192, 1, 3, "R10 immediate irq");
        exp_fill = (exp_fill + 12'd1) & mask;

        wait_rdy();
        wr(2'd3, cfgw(2'b01, 4'd5, 2'b01, 2'b01, 8'h00));
        chk(buf_rdy, "R8 drain keeps buffer offered", buf_rdy, 1);
        do_fill(exp_fill, 14'd64, 1, 3, "R10 immediate irq");
        exp_fill = (exp_fill + 12'd1) & mask;
        idle_cycles(10);
        chk(fetch_cnt == exp_fetch, "R8 no fetch after drain", fetch_cnt, exp_fetch);
        chk(chan_idle, "R9 idle after drain", chan_idle, 1);

        wr(2'd3, cfgw(2'b10, 4'd5, 2'b00, 2'b01, 8'h00));
        wait_rdy();
        wr(2'd3, 32'd0);
        chk(!buf_rdy, "R8 stop withdraws buffer", buf_rdy, 0);
        @(negedge clk);
        chk(chan_idle, "R9 idle after stop", chan_idle, 1);
        idle_cycles(10);
        chk(fill_idx == exp_fill, "R8 stop does not fill", fill_idx, exp_fill);
        chk(fetch_cnt == exp_fetch + 1, "R8 single fetch before stop", fetch_cnt, exp_fetch + 1);
        exp_fetch++;
        wr(2'd3, cfgw(2'b10, 4'd5, 2'b00, 2'b01, 8'h00));
        do_fill(exp_fill, 14'd200, 1, 3, "R8 refetch then immediate irq");
        exp_fill = (exp_fill + 12'd1) & mask;

        wr(2'd3, cfgw(2'b10, 4'd5, 2'b00, 2'b00, 8'h00));
        do_fill(exp_fill, 14'd300, 0, 5, "R11 no irq without host target");
        exp_fill = (exp_fill + 12'd1) & mask;

        tick_us = 1'b1;
        wr(2'd3, cfgw(2'b10, 4'd5, 2'b00, 2'b01, 8'h01));
        do_fill(exp_fill, 14'd400, 33, 40, "R11 timeout of one unit");
        exp_fill = (exp_fill + 12'd1) & mask;
        wr(2'd3, cfgw(2'b10, 4'd5, 2'b00, 2'b01, 8'h02));
        do_fill(exp_fill, 14'd500, 0, 40, "R11 no irq before restart");
        exp_fill = (exp_fill + 12'd1) & mask;
        do_fill(exp_fill, 14'd600, 65, 80, "R11 restart on fill");
        exp_fill = (exp_fill + 12'd1) & mask;
        tick_us = 1'b0;
        idle_cycles(5);
        chk(fill_idx == prod, "R5 full after last fill", fill_idx, prod);

        do_reset();
        wr(2'd3, cfgw(2'b10, 4'd4, 2'b00, 2'b01, 8'h00));
        wr(2'd2, 32'd32);
        idle_cycles(10);
        chk(fetch_cnt == 0, "R7 producer masked to ring size", fetch_cnt, 0);
        wr(2'd2, 32'd16);
        idle_cycles(10);
        chk(fetch_cnt == 1, "R7 size clamped to minimum", fetch_cnt, 1);
        chk(buf_rdy, "R7 buffer offered in clamped ring", buf_rdy, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule